// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flag-Tagged Receive Queue

This block recovers characters from an asynchronous serial line. A free-running clock drives it, and a one-cycle enable `tick16` pulses sixteen times per bit period. The block synchronises the line and hunts for a falling edge. It confirms the start bit at its centre, then samples each following bit at its centre. The character length and the parity mode come from static configuration inputs. Each finished character is stored together with three status flags: parity error, framing error and break.

After reset the block keeps a single holding register. A newer character overwrites an unread one in that register. When `fifo_en` is set, storage becomes a queue of `DEPTH` (16) entries, and each entry keeps its own flags. In queue mode, a character that arrives while the queue is full is thrown away. An `overrun` flag is raised in both modes and stays set until the status is read. The head entry is shown on the read outputs. `rd_en` removes the head entry. `rx_ready` is a request line for a DMA engine.

Top module: `uart_rx_fifo`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `data_ready`, `rx_ready` and `overrun` are 0, and the block is in single-register mode.
- R2: Every bit is sampled on the 8th `tick16` pulse of its 16-pulse period. Data arrives least significant bit first. With `cfg_len`=3 (8 bits) and no parity, a character appears whole on `rd_data` with all three flags clear.
- R3: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected length read as 0.
- R4: When `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 selects even parity and 0 selects odd parity. `rd_pe` is 1 exactly when the received parity bit is wrong. When `cfg_par_en`=0, `rd_pe` is 0.
- R5: If the line is high again at the centre of a start bit, the block drops the attempt, stores nothing, and goes back to waiting for a falling edge.
- R6: `rd_fe` is 1 when the first stop bit is sampled low. No further stop bit is checked, so frames with two stop bits are received normally. After a low stop bit, the block waits for the line to go high before it hunts for a new start.
- R7: A line held low through start, data, parity (if enabled) and first stop bit stores exactly one entry, with data 0, `rd_brk`=1, `rd_fe`=1 and `rd_pe`=0. The line must return high before another character can begin.
- R8: In single-register mode, a character that completes while the register holds unread data replaces it and sets `overrun`.
- R9: `overrun` stays set until a cycle with `stat_rd`=1 clears it. A new overrun in the same cycle takes priority over the clear.
- R10: When `fifo_en`=1, up to 16 characters queue in arrival order, each with its own flags. A character that arrives while 16 are held is dropped, the queue stays unchanged, and `overrun` is set.
- R11: `rd_en` removes the head entry when one is present and has no effect on an empty store. `rd_data` and the flags read 0 while `data_ready` is 0.
- R12: Any change of `fifo_en` empties the store on the next clock edge.
- R13: `rx_ready` equals `data_ready` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rd_en | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears `overrun` |
| rd_data | output | 8 | Head entry data |
| rd_pe | output | 1 | Head entry parity error |
| rd_fe | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_ready | output | 1 | At least one entry is stored |
| overrun | output | 1 | A character was lost or overwritten since the last status read |
| rx_ready | output | 1 | DMA request for receive data |

## Verification
The hardest state to reach is a full queue that receives one more character. Reaching it requires sixteen complete frames to land with no read in between, and the flags of those frames must differ so that a lost or shifted entry shows up. The stimulus first fills the queue with sixteen frames, one of them with wrong parity and one with a low stop bit. It then sends a seventeenth frame and drains the queue, checking the order and every flag of each entry. A framing error followed by a line that stays low until the stop bit ends is another state that is easy to get wrong, because a careless receiver takes it as a new start bit. The framing and break scenarios hold the line low in exactly this way.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: characters of at most 8 data bits.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // hunting for a falling edge
        S_START,  // confirming the start bit
        S_DATA,   // collecting data bits
        S_PAR,    // sampling the parity bit
        S_STOP,   // sampling the first stop bit
        S_HOLD    // line was low at the stop bit: wait for high
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of STAGES flops that reset to the idle (high) level.
// Assumes: STAGES >= 2.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
// Module: rx_frame
// Bit engine. It finds a start edge, checks the start bit at its centre,
// samples data (LSB first), the optional parity bit and the first stop bit
// at the centre of each bit, and produces one entry with its flags.
// Assumes: line already synchronised; configuration static within a frame.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_even,
    output logic      done,
    output rx_entry_t entry
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          all_zero;
    logic          par_bit;

    logic [7:0]    aligned;
    logic          par_err;
    logic [2:0]    last_idx;
    logic [1:0]    shamt;

    // Align the collected bits and evaluate parity for the current frame.
    always_comb begin
        shamt    = 2'd3 - cfg_len;
        aligned  = shreg >> shamt;
        last_idx = {1'b0, cfg_len} + 3'd4;
        par_err  = cfg_par_en & (^aligned ^ par_bit ^ ~cfg_par_even);
    end

    // Frame state machine, advanced on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            all_zero <= 1'b0;
            par_bit  <= 1'b0;
            done     <= 1'b0;
            entry    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!line) begin
                            state <= S_START;
                            cnt   <= CW'(1);
                        end
                    end
                    S_START: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID && line) begin
                            state <= S_IDLE;
                        end else if (cnt == LAST) begin
                            state    <= S_DATA;
                            cnt      <= '0;
                            bidx     <= '0;
                            all_zero <= 1'b1;
                        end
                    end
                    S_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID) begin
                            shreg <= {line, shreg[7:1]};
                            if (line) all_zero <= 1'b0;
                        end
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (bidx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
                            else                  bidx  <= bidx + 3'd1;
                        end
                    end
                    S_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID) begin
                            par_bit <= line;
                            if (line) all_zero <= 1'b0;
                        end
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= S_STOP;
                        end
                    end
                    S_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID) begin
                            done       <= 1'b1;
                            entry.brk  <= all_zero & ~line;
                            entry.fe   <= ~line;
                            entry.pe   <= (all_zero & ~line) ? 1'b0 : par_err;
                            entry.data <= (all_zero & ~line) ? 8'h00 : aligned;
                            state      <= line ? S_IDLE : S_HOLD;
                        end
                    end
                    S_HOLD: begin
                        if (line) state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_store.sv
// Module: rx_store
// Entry storage. In single mode it holds one entry and a newer entry
// replaces an unread one. In queue mode it holds DEPTH entries and drops
// new entries while full. Overrun is sticky until a status read. A change
// of mode empties the store.
// Assumes: DEPTH is a power of two, at least 2.
module rx_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en,
    input  logic      wr,
    input  rx_entry_t wentry,
    input  logic      rd,
    input  logic      stat_rd,
    output rx_entry_t head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic      ovr
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic           mode_q;
    logic [LW-1:0]  cap;
    logic           full, pop, push, ovw, ovr_set, flush;

    // Decode the store actions of this cycle.
    always_comb begin
        cap     = mode_q ? LW'(DEPTH) : LW'(1);
        full    = (level == cap);
        flush   = (fifo_en != mode_q);
        pop     = rd && (level != '0) && !flush;
        push    = wr && (!full || pop) && !flush;
        ovr_set = wr && full && !pop && !flush;
        ovw     = ovr_set && !mode_q;
    end

    // Pointers, fill level and mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp     <= '0;
            rp     <= '0;
            level  <= '0;
            mode_q <= 1'b0;
        end else if (flush) begin
            wp     <= '0;
            rp     <= '0;
            level  <= '0;
            mode_q <= fifo_en;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            level <= level + LW'(push) - LW'(pop);
        end
    end

    // Entry array write: append, or replace the single entry.
    always_ff @(posedge clk) begin
        if (push)     mem[wp] <= wentry;
        else if (ovw) mem[rp] <= wentry;
    end

    // Sticky overrun flag, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
        else if (stat_rd) ovr <= 1'b0;
    end

    assign head = mem[rp];

endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo
// Top of the serial receiver. It connects the synchroniser, the bit engine
// and the entry store, and shows the head entry (zeroed when empty).
// Assumes: tick16 is a one-cycle pulse, OSR pulses per bit period.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int OSR    = 16,
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       fifo_en,
    input  logic       rd_en,
    input  logic       stat_rd,
    output logic [7:0] rd_data,
    output logic       rd_pe,
    output logic       rd_fe,
    output logic       rd_brk,
    output logic       data_ready,
    output logic       overrun,
    output logic       rx_ready
);

    localparam int LW = $clog2(DEPTH + 1);

    logic          line_s;
    logic          wr_done;
    rx_entry_t     new_entry;
    rx_entry_t     head;
    logic [LW-1:0] level;

    rx_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    rx_frame #(.OSR(OSR)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .line        (line_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_even(cfg_par_even),
        .done        (wr_done),
        .entry       (new_entry)
    );

    rx_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .fifo_en(fifo_en),
        .wr     (wr_done),
        .wentry (new_entry),
        .rd     (rd_en),
        .stat_rd(stat_rd),
        .head   (head),
        .level  (level),
        .ovr    (overrun)
    );

    // Present the head entry, masked while the store is empty.
    always_comb begin
        data_ready = (level != '0);
        rx_ready   = data_ready;
        rd_data    = data_ready ? head.data : 8'h00;
        rd_pe      = data_ready & head.pe;
        rd_fe      = data_ready & head.fe;
        rd_brk     = data_ready & head.brk;
    end

endmodule

// File: rtl/uart_rx_fifo_chk.sv
// Module: uart_rx_fifo_chk
// Property checker bound into uart_rx_fifo. It watches the fill level,
// the overrun flag and the mode input.
module uart_rx_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_en,
    input logic                       rd_en,
    input logic                       stat_rd,
    input logic                       wr_done,
    input logic                       overrun,
    input logic                       data_ready,
    input logic [7:0]                 rd_data,
    input logic [$clog2(DEPTH+1)-1:0] level
);

    // R10: the level never exceeds the queue depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH+1))'(DEPTH));

    // R8: single-register mode holds at most one entry
    a_r8_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en)) |-> (level <= 1));

    // R10: a full queue keeps its head while no read happens
    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $past(fifo_en) && level == ($clog2(DEPTH+1))'(DEPTH) && !rd_en)
        |=> (level == ($clog2(DEPTH+1))'(DEPTH) && $stable(rd_data)));

    // R9: overrun stays set without a status read
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun);

    // R9: overrun rises only after a character completes
    a_r9_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(wr_done));

    // R11: a read with no arrival and no mode change lowers the level by one
    a_r11_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_en && !wr_done && fifo_en == $past(fifo_en))
        |=> (level == $past(level) - 1'b1));

    // R12: a mode change empties the store
    a_r12_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != $past(fifo_en)) |=> !data_ready);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .rd_en     (rd_en),
    .stat_rd   (stat_rd),
    .wr_done   (wr_done),
    .overrun   (overrun),
    .data_ready(data_ready),
    .rd_data   (rd_data),
    .level     (level)
);

// File: tb/uart_rx_fifo_tb.sv
// Directed bench for uart_rx_fifo: one task for each scenario.
module uart_rx_fifo_tb;

    localparam int BT = 64;   // clocks per bit: 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_pe, rd_fe, rd_brk, data_ready, overrun, rx_ready;
    logic [1:0] div = 2'd0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    // Oversampling enable: one pulse every 4 clocks.
    always_ff @(posedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd3);
    end

    uart_rx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .fifo_en(fifo_en), .rd_en(rd_en), .stat_rd(stat_rd),
        .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_brk(rd_brk),
        .data_ready(data_ready), .overrun(overrun), .rx_ready(rx_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nb, input logic even);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        return even ? x : ~x;
    endfunction

    // Send one frame: start, nb data bits LSB first, optional parity, stop bits.
    task automatic send(input logic [7:0] d, input int nb, input logic pen,
                        input logic pbit, input logic stopv, input int nstop);
        rxd = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (BT) @(negedge clk);
        end
        if (pen) begin
            rxd = pbit;
            repeat (BT) @(negedge clk);
        end
        for (int s = 0; s < nstop; s++) begin
            rxd = (s == 0) ? stopv : 1'b1;
            repeat (BT) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BT / 2) @(negedge clk);
    endtask

    // Check the head entry, then remove it.
    task automatic pop_chk(input string req, input logic [7:0] d,
                           input logic pe, input logic fe, input logic brk);
        @(negedge clk);
        check({req, " ready"}, data_ready, 1);
        check({req, " data"}, rd_data, d);
        check({req, " flags"}, {rd_brk, rd_fe, rd_pe}, {brk, fe, pe});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", data_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", data_ready, 0);
        check("R1 overrun after reset", overrun, 0);
        check("R13 rx_ready after reset", rx_ready, 0);
    endtask

    task automatic t_basic;
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        send(8'hA5, 8, 0, 0, 1, 1);
        check("R13 rx_ready with data", rx_ready, 1);
        pop_chk("R2 8N1 A5", 8'hA5, 0, 0, 0);
        send(8'h3C, 8, 0, 0, 1, 2);   // R6: two stop bits
        pop_chk("R6 two stop bits", 8'h3C, 0, 0, 0);
        check("R11 empty after read", data_ready, 0);
        check("R13 rx_ready empty", rx_ready, 0);
    endtask

    task automatic t_lengths;
        cfg_par_en = 1'b0;
        for (int l = 0; l < 3; l++) begin
            cfg_len = 2'(l);
            send(8'hFF, l + 5, 0, 0, 1, 1);
            pop_chk("R3 length", 8'((1 << (l + 5)) - 1), 0, 0, 0);
        end
        cfg_len = 2'd1;
        send(8'h2A, 6, 0, 0, 1, 1);
        pop_chk("R3 six bit pattern", 8'h2A, 0, 0, 0);
        cfg_len = 2'd3;
    endtask

    task automatic t_parity;
        cfg_par_en = 1'b1; cfg_len = 2'd2;
        cfg_par_even = 1'b1;
        send(8'h55, 7, 1, par_of(8'h55, 7, 1), 1, 1);
        pop_chk("R4 even good", 8'h55, 0, 0, 0);
        cfg_par_even = 1'b0;
        send(8'h13, 7, 1, par_of(8'h13, 7, 0), 1, 1);
        pop_chk("R4 odd good", 8'h13, 0, 0, 0);
        cfg_len = 2'd3; cfg_par_even = 1'b1;
        send(8'hC3, 8, 1, ~par_of(8'hC3, 8, 1), 1, 1);
        pop_chk("R4 even bad", 8'hC3, 1, 0, 0);
        cfg_par_en = 1'b0;
    endtask

    task automatic t_false_start;
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BT) @(negedge clk);
        check("R5 glitch stores nothing", data_ready, 0);
        send(8'h81, 8, 0, 0, 1, 1);
        pop_chk("R5 next frame intact", 8'h81, 0, 0, 0);
    endtask

    task automatic t_framing;
        send(8'h6E, 8, 0, 0, 0, 1);
        pop_chk("R6 low stop", 8'h6E, 0, 1, 0);
        check("R6 single entry", data_ready, 0);
    endtask

    task automatic t_break;
        rxd = 1'b0;
        repeat (12 * BT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BT) @(negedge clk);
        pop_chk("R7 break entry", 8'h00, 0, 1, 1);
        check("R7 one break entry", data_ready, 0);
    endtask

    task automatic t_char_overrun;
        send(8'h11, 8, 0, 0, 1, 1);
        send(8'h22, 8, 0, 0, 1, 1);
        @(negedge clk);
        check("R8 overrun set", overrun, 1);
        check("R8 newest kept", rd_data, 8'h22);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
        check("R9 overrun cleared", overrun, 0);
        pop_chk("R8 single entry", 8'h22, 0, 0, 0);
        check("R8 one entry only", data_ready, 0);
    endtask

    task automatic t_empty_read;
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check("R11 empty read", data_ready, 0);
        check("R11 empty outputs", {rd_data, rd_pe, rd_fe, rd_brk}, 0);
        send(8'h5A, 8, 0, 0, 1, 1);
        pop_chk("R11 after empty read", 8'h5A, 0, 0, 0);
        check("R11 level back to 0", data_ready, 0);
    endtask

    task automatic t_fifo;
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        fifo_en = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d = 8'(8'h10 + i);
            logic p = par_of(d, 8, 1);
            send(d, 8, 1, (i == 3) ? ~p : p, (i == 7) ? 1'b0 : 1'b1, 1);
        end
        check("R10 no overrun at 16", overrun, 0);
        send(8'hEE, 8, 1, par_of(8'hEE, 8, 1), 1, 1);
        check("R10 overrun on 17th", overrun, 1);
        for (int i = 0; i < 16; i++)
            pop_chk("R10 order and flags", 8'(8'h10 + i), (i == 3), (i == 7), 0);
        check("R10 17th dropped", data_ready, 0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
        check("R9 overrun cleared in queue mode", overrun, 0);
        cfg_par_en = 1'b0;
    endtask

    task automatic t_mode_flush;
        send(8'h71, 8, 0, 0, 1, 1);
        send(8'h72, 8, 0, 0, 1, 1);
        check("R12 two held", data_ready, 1);
        fifo_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 flushed on mode change", data_ready, 0);
        send(8'h99, 8, 0, 0, 1, 1);
        pop_chk("R12 single mode after flush", 8'h99, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_false_start();
        t_framing();
        t_break();
        t_char_overrun();
        t_empty_read();
        t_fifo();
        t_mode_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule